// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block connects an 8-bit microcontroller bus, whose eight shared pins carry first the low address byte and then data, to an internal memory port. The high address bits come in on separate pins. While the address strobe is low, the internal address follows the pins. When the strobe rises, the 13-bit address is frozen. A data strobe and a read/write line then move one byte. On a read, the block asks the memory for the byte and drives it onto the shared pins through a tri-state enable. On a write, it captures the byte from the pins and issues a single-cycle write request.

Every pin is sampled on the system clock through a two-stage synchronizer. All edges are detected on the synchronized copies, so every response trails the pin activity by a fixed number of clocks. Chip enable is active high. When it is low, no strobe has any effect and the pins are released.

Top module: `mux_bus_slave`

## Requirements
- R1: After a synchronous reset, `rd_req`, `wr_req` and `ad_oe` are 0.
- R2: While `astb` is low, `req_addr` equals `{addr_hi, ad_in}` from the third clock after a pin change onward. `addr_hi` supplies bits 12..8 and `ad_in` supplies bits 7..0.
- R3: After `astb` rises, `req_addr` keeps the last value it held while `astb` was low, even if `ad_in` and `addr_hi` change afterwards.
- R4: With `ce`=1 and `rd_wr`=0, a rising edge on `dstb` produces a `wr_req` pulse exactly one clock wide, three clocks after the edge. `wr_data` carries the byte present on `ad_in` at that edge.
- R5: With `ce`=1 and `rd_wr`=1, a falling edge on `dstb` produces a `rd_req` pulse exactly one clock wide, three clocks after the edge.
- R6: The clock after `rd_req`, the block samples `rd_data` into `ad_out` and raises `ad_oe`. `ad_out` then holds that byte for as long as `ad_oe` stays high.
- R7: Three clocks after `dstb` rises, `ad_oe` is 0.
- R8: While `ce` is 0, strobes produce no request. Three clocks after `ce` falls, `ad_oe` is 0 (standby).
- R9: A rising `dstb` with `rd_wr`=1 produces no `wr_req`. A falling `dstb` with `rd_wr`=0 produces no `rd_req`.
- R10: If `dstb` rises in the same synchronized cycle in which read data would be captured, the release wins and `ad_oe` stays 0.
- R11: `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 8 | Shared pins, input side: low address byte, then write data |
| ad_out | output | 8 | Shared pins, output side: read data |
| ad_oe | output | 1 | Tri-state enable for `ad_out` |
| addr_hi | input | 5 | High address bits 12..8 |
| astb | input | 1 | Address strobe: address follows the pins while low, frozen on rise |
| dstb | input | 1 | Data strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ce | input | 1 | Chip enable, active high |
| rd_data | input | 8 | Byte returned by memory one clock after `rd_req` |
| rd_req | output | 1 | Single-cycle read request |
| wr_req | output | 1 | Single-cycle write request |
| req_addr | output | 13 | Latched address for both requests |
| wr_data | output | 8 | Byte captured for the write |

## Verification
Two events can land in the same synchronized cycle. The first pair is the address strobe rising and the data strobe falling. The bench changes `astb`, `dstb` and the address pins on one edge and expects the read to use the address that was present before the change. The second pair is the read-data capture and the output release. A one-clock `dstb` low pulse puts the release in the capture cycle, and the bench judges the result by `rd_req` being seen while `ad_oe` never rises.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic ce;
    logic rd_wr;
    logic astb;
    logic dstb;
  } ctl_t;

  // Pin values assumed while the synchronizers are in reset: strobes idle high.
  localparam ctl_t CTL_IDLE = '{ce: 1'b0, rd_wr: 1'b1, astb: 1'b1, dstb: 1'b1};
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stg <= {STAGES{RST_VAL}};
      else     stg <= {stg[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stg <= RST_VAL;
      else     stg <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbs_edge.sv
module mbs_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= sig;
  end

  assign rise = sig & ~prev;
  assign fall = ~sig & prev;
endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            open_win,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  output logic [AW-1:0]   addr
);
  always_ff @(posedge clk) begin
    if (rst)           addr <= '0;
    else if (open_win) addr <= {hi, lo};
  end
endmodule

// File: rtl/mbs_xfer_ctrl.sv
module mbs_xfer_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          rd_wr,
  input  logic          ds_rise,
  input  logic          ds_fall,
  input  logic [DW-1:0] bus,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic rd_go, wr_go, release_now;

  assign rd_go       = ds_fall & ce & rd_wr;
  assign wr_go       = ds_rise & ce & ~rd_wr;
  assign release_now = ds_rise | ~ce;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
      oe      <= 1'b0;
      dout    <= '0;
    end else begin
      rd_req <= rd_go;
      wr_req <= wr_go;
      if (wr_go) wr_data <= bus;
      // rd_req doubles as the "data returns now" marker; release has priority
      if (release_now) begin
        oe <= 1'b0;
      end else if (rd_req) begin
        oe   <= 1'b1;
        dout <= rd_data;
      end
    end
  end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LO_W-1:0]      ad_in,
  output logic [LO_W-1:0]      ad_out,
  output logic                 ad_oe,
  input  logic [HI_W-1:0]      addr_hi,
  input  logic                 astb,
  input  logic                 dstb,
  input  logic                 rd_wr,
  input  logic                 ce,
  input  logic [LO_W-1:0]      rd_data,
  output logic                 rd_req,
  output logic                 wr_req,
  output logic [LO_W+HI_W-1:0] req_addr,
  output logic [LO_W-1:0]      wr_data
);
  localparam int SYNC_W = LO_W + HI_W + CTL_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{(LO_W+HI_W){1'b0}}, CTL_IDLE};

  ctl_t            ctl_pin, ctl_s;
  logic [LO_W-1:0] bus_s;
  logic [HI_W-1:0] hi_s;
  logic            ds_rise, ds_fall;

  assign ctl_pin = '{ce: ce, rd_wr: rd_wr, astb: astb, dstb: dstb};

  mbs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({ad_in, addr_hi, ctl_pin}),
    .q({bus_s, hi_s, ctl_s})
  );

  mbs_edge #(.W(1), .RST_VAL(1'b1)) u_ds_edge (
    .clk(clk), .rst(rst), .sig(ctl_s.dstb), .rise(ds_rise), .fall(ds_fall)
  );

  mbs_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_alatch (
    .clk(clk), .rst(rst), .open_win(~ctl_s.astb),
    .lo(bus_s), .hi(hi_s), .addr(req_addr)
  );

  mbs_xfer_ctrl #(.DW(LO_W)) u_xfer (
    .clk(clk), .rst(rst), .ce(ctl_s.ce), .rd_wr(ctl_s.rd_wr),
    .ds_rise(ds_rise), .ds_fall(ds_fall), .bus(bus_s), .rd_data(rd_data),
    .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .oe(ad_oe), .dout(ad_out)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req,
  input logic          wr_req,
  input logic          ad_oe,
  input logic [DW-1:0] ad_out
);
  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_oe_follows_rd_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(rd_req));

  assert_dout_held_R6: assert property (@(posedge clk) disable iff (rst)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_out));
endmodule

bind mux_bus_slave mbs_checker #(.DW(LO_W)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
  .ad_oe(ad_oe), .ad_out(ad_out)
);

// File: tb/mux_bus_slave_test.sv
module mux_bus_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ad_in = 8'h00;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [4:0]  addr_hi = 5'h00;
  logic        astb = 1'b1, dstb = 1'b1, rd_wr = 1'b1, ce = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_req, wr_req;
  logic [12:0] req_addr;
  logic [7:0]  wr_data;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  mux_bus_slave uut (
    .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .astb(astb), .dstb(dstb), .rd_wr(rd_wr), .ce(ce),
    .rd_data(rd_data), .rd_req(rd_req), .wr_req(wr_req),
    .req_addr(req_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] mem_of(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction
  assign rd_data = mem_of(req_addr);

  typedef struct packed { logic rw; logic [12:0] addr; logic [7:0] data; } vec_t;
  localparam vec_t VECS [0:5] = '{
    '{1'b0, 13'h0000, 8'h3C},
    '{1'b1, 13'h1FFF, 8'h00},
    '{1'b0, 13'h0555, 8'hAA},
    '{1'b1, 13'h0AAA, 8'h00},
    '{1'b0, 13'h1234, 8'h5A},
    '{1'b1, 13'h1000, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count cycles in which a request is seen over n cycles
  task automatic watch(input int n, output int rd_seen, output int wr_seen, output int oe_seen);
    rd_seen = 0; wr_seen = 0; oe_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_seen += int'(rd_req); wr_seen += int'(wr_req); oe_seen += int'(ad_oe);
    end
  endtask

  task automatic set_addr(input logic [12:0] a, input logic rw);
    @(negedge clk);
    ce = 1'b1; rd_wr = rw; astb = 1'b0; dstb = 1'b1;
    ad_in = a[7:0]; addr_hi = a[12:8];
    step(3);
    check("R2 address follows pins", req_addr, a);
    astb = 1'b1; addr_hi = ~a[12:8];
  endtask

  task automatic txn(input vec_t v);
    int r, w, o;
    set_addr(v.addr, v.rw);
    ad_in = v.rw ? 8'h00 : v.data;
    step(3);
    check("R3 address held after strobe", req_addr, v.addr);
    if (!v.rw) begin
      dstb = 1'b0;
      watch(3, r, w, o);
      check("R9 no read on write cycle", r, 0);
      dstb = 1'b1;
      step(2);
      check("R4 write not early", wr_req, 0);
      step(1);
      check("R4 write pulse", wr_req, 1);
      check("R4 write data", wr_data, v.data);
      check("R4 write address", req_addr, v.addr);
      step(1);
      check("R4 write pulse width", wr_req, 0);
    end else begin
      dstb = 1'b0;
      step(3);
      check("R5 read pulse", rd_req, 1);
      step(1);
      check("R5 read pulse width", rd_req, 0);
      check("R6 output enable", ad_oe, 1);
      check("R6 read data", ad_out, mem_of(v.addr));
      step(2);
      check("R6 data held", ad_out, mem_of(v.addr));
      dstb = 1'b1;
      step(2);
      check("R7 still driving", ad_oe, 1);
      step(1);
      check("R7 released", ad_oe, 0);
      watch(3, r, w, o);
      check("R9 no write on read release", w, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, w, o;
    step(4);
    rst = 1'b0;
    step(1);
    check("R1 rd_req reset", rd_req, 0);
    check("R1 wr_req reset", wr_req, 0);
    check("R1 ad_oe reset", ad_oe, 0);

    for (int i = 0; i < 6; i++) txn(VECS[i]);

    // R8: chip enable low blocks both strobe directions
    set_addr(13'h0123, 1'b0);
    ce = 1'b0; ad_in = 8'hEE;
    step(3);
    dstb = 1'b0;
    watch(4, r, w, o);
    dstb = 1'b1;
    watch(5, r, w, o);
    check("R8 no write when disabled", w, 0);
    rd_wr = 1'b1; dstb = 1'b0;
    watch(5, r, w, o);
    check("R8 no read when disabled", r, 0);
    check("R8 no drive when disabled", o, 0);
    dstb = 1'b1;
    step(3);

    // R8 standby: drop enable in the middle of a read
    set_addr(13'h0F0F, 1'b1);
    step(3);
    dstb = 1'b0;
    step(4);
    check("R8 read driving before standby", ad_oe, 1);
    ce = 1'b0;
    step(2);
    check("R8 still driving", ad_oe, 1);
    step(1);
    check("R8 standby releases bus", ad_oe, 0);
    dstb = 1'b1;
    step(3);

    // R10: one-clock data strobe low, release meets capture
    set_addr(13'h0777, 1'b1);
    step(3);
    dstb = 1'b0;
    step(1);
    dstb = 1'b1;
    step(2);
    check("R10 read requested", rd_req, 1);
    watch(4, r, w, o);
    check("R10 release wins over capture", o, 0);

    // R3/R5: address strobe rise and data strobe fall together
    @(negedge clk);
    ce = 1'b1; rd_wr = 1'b1; astb = 1'b0; ad_in = 8'h42; addr_hi = 5'h15;
    step(3);
    astb = 1'b1; dstb = 1'b0; ad_in = 8'h99; addr_hi = 5'h02;
    step(3);
    check("R5 read with simultaneous strobes", rd_req, 1);
    check("R3 address before strobe edge", req_addr, 13'h1542);
    step(1);
    check("R6 data from pre-edge address", ad_out, mem_of(13'h1542));
    dstb = 1'b1;
    step(4);
    check("R7 released after concurrent read", ad_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule